// File: doc/BRIEF.md
# Per-Scanline Sprite Evaluator

This block decides, once per scanline, which sprites will be drawn on the next line. It reads a 256-byte sprite attribute window through a synchronous read port with one cycle of latency. The window holds one vertical position byte per sprite in its lower half. The upper half holds a horizontal position byte and a pattern byte for each sprite, side by side. When `lineStart` is pulsed with the number of the line to prepare, the block walks the sprites in ascending index order. It keeps up to eight hits as slot records. Each record carries the horizontal start, the byte address of the pattern row to fetch, and the sprite index. The walk stops at the terminator value 0xD0, at the end of the table, or when a ninth hit is found. A ninth hit raises a sticky overflow flag.

A companion mixing stage sits beside the evaluator. Pattern shifters outside the block supply one 4-bit colour per slot for each pixel. The mixer picks the lowest-numbered opaque slot and lets a background pixel that has its priority flag set cover it. It outputs the final 5-bit colour index. It also raises a sticky collision flag whenever two or more opaque sprite pixels land on the same screen pixel. Both status flags are cleared by `statusAck`.

Top module: `sprite_evaluator`

## Requirements
- R1: Sprite n (n = 0..63) has its vertical byte at window offset n, its horizontal byte at offset 0x80+2n and its pattern byte at offset 0x81+2n. Sprites are examined in ascending n, and hits fill slots 0,1,2,... in that order, with `slotIndex` holding n.
- R2: For a prepared line L and a vertical byte Y, let d = (L − Y − 1) mod 256. The sprite is on the line when d is less than the sprite height, and d is the sprite row. So Y = 0xFF hits line 0 at row 0, and Y values near 0xF0–0xFF wrap onto the top lines.
- R3: A vertical byte of 0xD0 ends the walk. That sprite and every later one are neither stored nor counted toward overflow.
- R4: The height is 8, or 16 when `tallMode` is 1. `slotRowAddr` (13 bits) is {P, row[2:0], 2'b00}. In normal mode P is the pattern byte. In tall mode P is {pattern[7:1], row[3]}, so the upper half uses the even pattern and the lower half uses the next one.
- R5: At most eight slots are filled, and `spriteCount` is always in the range 0..8.
- R6: A hit found while all eight slots are full sets `statusOverflow` and ends the walk. The flag stays set until a `statusAck` pulse in a cycle where no new overflow is being set.
- R7: When `earlyClock` is 0, `slotX` is the horizontal byte zero-extended to 9 bits. When it is 1, `slotX` is that value minus 8, in 9-bit two's complement (for example, 3 becomes 0x1FB).
- R8: `evalDone` is a one-cycle pulse, and slot outputs, count and overflow are final in that cycle. `lineStart` is ignored while a walk is in progress.
- R9: A slot takes part in mixing only if its number is below `spriteCount` and its colour is nonzero. The lowest such slot wins. `pixSprite` is then 1 and `pixOut` is {1'b1, colour}, the upper palette.
- R10: When `bgPriority` is 1 and `bgPixel[3:0]` is nonzero, the sprite is hidden: `pixSprite` is 0 and `pixOut` equals `bgPixel`. With no winning sprite, `pixOut` also equals `bgPixel`.
- R11: When `pixValid` is 1 and two or more slots take part in mixing, `statusCollision` is set on the next clock edge. The flag stays set until a `statusAck` pulse with no new collision in that cycle.
- R12: After reset, `spriteCount` is 0, `evalDone` is 0 and both status flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineStart | input | 1 | Start a walk for `lineNum` |
| lineNum | input | 8 | Line to prepare |
| tallMode | input | 1 | 1 selects 16-pixel-tall sprites |
| earlyClock | input | 1 | 1 shifts every sprite 8 pixels left |
| tblAddr | output | 8 | Attribute window read address |
| tblData | input | 8 | Read data, valid one cycle after address |
| evalDone | output | 1 | Walk finished pulse |
| spriteCount | output | 4 | Number of filled slots |
| slotX | output | 72 | Per-slot 9-bit horizontal start, slot s at [9s+8:9s] |
| slotRowAddr | output | 104 | Per-slot 13-bit pattern row address, slot s at [13s+12:13s] |
| slotIndex | output | 48 | Per-slot 6-bit sprite index |
| statusOverflow | output | 1 | Sticky ninth-sprite flag |
| statusAck | input | 1 | Clears both status flags |
| pixValid | input | 1 | Current pixel is on the visible screen |
| slotColor | input | 32 | Per-slot 4-bit colour for the current pixel |
| bgPixel | input | 5 | Background colour index {palette, colour} |
| bgPriority | input | 1 | Background tile wants to cover sprites |
| pixOut | output | 5 | Mixed colour index |
| pixSprite | output | 1 | Sprite pixel shown |
| statusCollision | output | 1 | Sticky sprite collision flag |

## Verification
The evaluator is tested with directed lines that isolate one rule at a time. A Y of 0xFF on line 0 confirms the off-by-one rule. A wrapped Y in tall mode tells a wrapped lower row apart from a missed sprite. A terminator placed before an in-range sprite separates stopping from skipping. Ten stacked sprites show that exactly the first eight are kept and that overflow is raised. A negative early-clock start checks the 9-bit wrap. Random tables with Y values clustered around the line mix hits, misses, terminators and both heights, and the slot lists are compared field by field with a model of the rules. The mixer is fed masked slots, priority backgrounds with opaque and transparent colours, and random colour sets, which tells winner selection apart from collision detection.

// File: rtl/sprite_eval_pkg.sv
package sprite_eval_pkg;

  typedef struct packed {
    logic clearList;
    logic latchRow;
    logic latchX;
    logic storeRec;
    logic setOverflow;
  } evalStrobes_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH_Y,
    ST_TEST_Y,
    ST_GET_X,
    ST_GET_P
  } evalState_t;

endpackage

// File: rtl/sprite_eval_ctrl.sv
module sprite_eval_ctrl
  import sprite_eval_pkg::*;
#(
  parameter int NUM_SPRITES = 64,
  parameter int IDX_W = $clog2(NUM_SPRITES),
  parameter int ADDR_W = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineStart,
  input  logic              yHit,
  input  logic              yTerm,
  input  logic              listFull,
  output evalStrobes_t      strobe,
  output logic [IDX_W-1:0]  curIdx,
  output logic [ADDR_W-1:0] tblAddr,
  output logic              evalDone
);

  evalState_t state, nextState;
  logic [IDX_W-1:0] idx;
  logic advance, finish, lastIdx;

  assign lastIdx = (idx == IDX_W'(NUM_SPRITES - 1));
  assign curIdx  = idx;

  // Address shown in a state is read back in the following state.
  always_comb begin
    case (state)
      ST_TEST_Y: tblAddr = {1'b1, idx, 1'b0};
      ST_GET_X:  tblAddr = {1'b1, idx, 1'b1};
      default:   tblAddr = {2'b00, idx};
    endcase
  end

  always_comb begin
    strobe    = '0;
    nextState = state;
    advance   = 1'b0;
    finish    = 1'b0;
    case (state)
      ST_IDLE: begin
        if (lineStart) begin
          strobe.clearList = 1'b1;
          nextState = ST_FETCH_Y;
        end
      end
      ST_FETCH_Y: nextState = ST_TEST_Y;
      ST_TEST_Y: begin
        if (yTerm) begin
          finish = 1'b1;
        end else if (yHit) begin
          if (listFull) begin
            strobe.setOverflow = 1'b1;
            finish = 1'b1;
          end else begin
            strobe.latchRow = 1'b1;
            nextState = ST_GET_X;
          end
        end else if (lastIdx) begin
          finish = 1'b1;
        end else begin
          advance = 1'b1;
          nextState = ST_FETCH_Y;
        end
      end
      ST_GET_X: begin
        strobe.latchX = 1'b1;
        nextState = ST_GET_P;
      end
      ST_GET_P: begin
        strobe.storeRec = 1'b1;
        if (lastIdx) begin
          finish = 1'b1;
        end else begin
          advance = 1'b1;
          nextState = ST_FETCH_Y;
        end
      end
      default: nextState = ST_IDLE;
    endcase
    if (finish) nextState = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      idx      <= '0;
      evalDone <= 1'b0;
    end else begin
      state    <= nextState;
      evalDone <= finish;
      if (strobe.clearList) idx <= '0;
      else if (advance)     idx <= idx + IDX_W'(1);
    end
  end

endmodule

// File: rtl/sprite_eval_dp.sv
module sprite_eval_dp
  import sprite_eval_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int IDX_W = 6,
  parameter int CNT_W = $clog2(NUM_SLOTS + 1),
  parameter logic [7:0] TERM_Y = 8'hD0
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  evalStrobes_t             strobe,
  input  logic [7:0]               lineNum,
  input  logic                     tallMode,
  input  logic                     earlyClock,
  input  logic [7:0]               tblData,
  input  logic [IDX_W-1:0]         curIdx,
  input  logic                     statusAck,
  output logic                     yHit,
  output logic                     yTerm,
  output logic                     listFull,
  output logic [CNT_W-1:0]         spriteCount,
  output logic [NUM_SLOTS*9-1:0]   slotX,
  output logic [NUM_SLOTS*13-1:0]  slotRowAddr,
  output logic [NUM_SLOTS*IDX_W-1:0] slotIndex,
  output logic                     statusOverflow
);

  logic [7:0] lineReg, xReg, diff, heightLim, patEff;
  logic [3:0] rowReg;
  logic tallReg, earlyReg;
  logic [8:0] xShifted;
  logic [12:0] rowAddr;

  assign diff      = lineReg - tblData - 8'd1;
  assign heightLim = tallReg ? 8'd16 : 8'd8;
  assign yTerm     = (tblData == TERM_Y);
  assign yHit      = !yTerm && (diff < heightLim);
  assign listFull  = (spriteCount == CNT_W'(NUM_SLOTS));

  assign xShifted = earlyReg ? ({1'b0, xReg} - 9'd8) : {1'b0, xReg};
  assign patEff   = tallReg ? {tblData[7:1], rowReg[3]} : tblData;
  assign rowAddr  = {patEff, rowReg[2:0], 2'b00};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineReg <= '0; tallReg <= 1'b0; earlyReg <= 1'b0;
      rowReg <= '0; xReg <= '0; spriteCount <= '0;
      statusOverflow <= 1'b0;
    end else begin
      if (strobe.clearList) begin
        lineReg  <= lineNum;
        tallReg  <= tallMode;
        earlyReg <= earlyClock;
        spriteCount <= '0;
      end else if (strobe.storeRec) begin
        spriteCount <= spriteCount + CNT_W'(1);
      end
      if (strobe.latchRow) rowReg <= diff[3:0];
      if (strobe.latchX)   xReg   <= tblData;
      if (strobe.setOverflow) statusOverflow <= 1'b1;
      else if (statusAck)     statusOverflow <= 1'b0;
    end
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotX[s*9 +: 9]             <= '0;
        slotRowAddr[s*13 +: 13]     <= '0;
        slotIndex[s*IDX_W +: IDX_W] <= '0;
      end else if (strobe.storeRec && spriteCount == CNT_W'(s)) begin
        slotX[s*9 +: 9]             <= xShifted;
        slotRowAddr[s*13 +: 13]     <= rowAddr;
        slotIndex[s*IDX_W +: IDX_W] <= curIdx;
      end
    end
  end

endmodule

// File: rtl/sprite_line_mixer.sv
module sprite_line_mixer #(
  parameter int NUM_SLOTS = 8,
  parameter int CNT_W = $clog2(NUM_SLOTS + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   pixValid,
  input  logic [NUM_SLOTS*4-1:0] slotColor,
  input  logic [CNT_W-1:0]       spriteCount,
  input  logic [4:0]             bgPixel,
  input  logic                   bgPriority,
  input  logic                   statusAck,
  output logic [4:0]             pixOut,
  output logic                   pixSprite,
  output logic                   statusCollision
);

  logic [NUM_SLOTS-1:0] opaque;
  logic [3:0] winColor;
  logic hidden, multiHit;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_opq
    assign opaque[s] = (CNT_W'(s) < spriteCount) && (slotColor[s*4 +: 4] != 4'd0);
  end

  always_comb begin
    winColor = 4'd0;
    for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
      if (opaque[s]) winColor = slotColor[s*4 +: 4];
    end
  end

  assign hidden    = bgPriority && (bgPixel[3:0] != 4'd0);
  assign pixSprite = (|opaque) && !hidden;
  assign pixOut    = pixSprite ? {1'b1, winColor} : bgPixel;
  assign multiHit  = pixValid && ($countones(opaque) >= 2);

  always_ff @(posedge clk) begin
    if (!rstN)          statusCollision <= 1'b0;
    else if (multiHit)  statusCollision <= 1'b1;
    else if (statusAck) statusCollision <= 1'b0;
  end

endmodule

// File: rtl/sprite_evaluator.sv
module sprite_evaluator
  import sprite_eval_pkg::*;
#(
  parameter int NUM_SPRITES = 64,
  parameter int NUM_SLOTS = 8,
  parameter logic [7:0] TERM_Y = 8'hD0,
  localparam int IDX_W = $clog2(NUM_SPRITES),
  localparam int ADDR_W = IDX_W + 2,
  localparam int CNT_W = $clog2(NUM_SLOTS + 1)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       lineStart,
  input  logic [7:0]                 lineNum,
  input  logic                       tallMode,
  input  logic                       earlyClock,
  output logic [ADDR_W-1:0]          tblAddr,
  input  logic [7:0]                 tblData,
  output logic                       evalDone,
  output logic [CNT_W-1:0]           spriteCount,
  output logic [NUM_SLOTS*9-1:0]     slotX,
  output logic [NUM_SLOTS*13-1:0]    slotRowAddr,
  output logic [NUM_SLOTS*IDX_W-1:0] slotIndex,
  output logic                       statusOverflow,
  input  logic                       statusAck,
  input  logic                       pixValid,
  input  logic [NUM_SLOTS*4-1:0]     slotColor,
  input  logic [4:0]                 bgPixel,
  input  logic                       bgPriority,
  output logic [4:0]                 pixOut,
  output logic                       pixSprite,
  output logic                       statusCollision
);

  evalStrobes_t strobe;
  logic [IDX_W-1:0] curIdx;
  logic yHit, yTerm, listFull;

  sprite_eval_ctrl #(.NUM_SPRITES(NUM_SPRITES), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk, .rstN, .lineStart, .yHit, .yTerm, .listFull,
    .strobe, .curIdx, .tblAddr, .evalDone
  );

  sprite_eval_dp #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W), .CNT_W(CNT_W), .TERM_Y(TERM_Y)) u_dp (
    .clk, .rstN, .strobe, .lineNum, .tallMode, .earlyClock, .tblData, .curIdx,
    .statusAck, .yHit, .yTerm, .listFull, .spriteCount, .slotX, .slotRowAddr,
    .slotIndex, .statusOverflow
  );

  sprite_line_mixer #(.NUM_SLOTS(NUM_SLOTS), .CNT_W(CNT_W)) u_mix (
    .clk, .rstN, .pixValid, .slotColor, .spriteCount, .bgPixel, .bgPriority,
    .statusAck, .pixOut, .pixSprite, .statusCollision
  );

endmodule

// File: rtl/sprite_eval_checker.sv
module sprite_eval_checker #(
  parameter int NUM_SLOTS = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic [CNT_W-1:0] spriteCount,
  input logic             statusOverflow,
  input logic             evalDone,
  input logic             pixSprite,
  input logic [4:0]       pixOut,
  input logic [4:0]       bgPixel,
  input logic             bgPriority,
  input logic             statusCollision,
  input logic             pixValid
);

  assert_count_limit_R5: assert property (@(posedge clk) disable iff (!rstN)
    spriteCount <= CNT_W'(NUM_SLOTS));

  assert_overflow_full_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusOverflow) |-> spriteCount == CNT_W'(NUM_SLOTS));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    evalDone |=> !evalDone);

  assert_sprite_upper_R9: assert property (@(posedge clk) disable iff (!rstN)
    pixSprite |-> (pixOut[4] && pixOut[3:0] != 4'd0));

  assert_priority_hide_R10: assert property (@(posedge clk) disable iff (!rstN)
    (bgPriority && bgPixel[3:0] != 4'd0) |-> (!pixSprite && pixOut == bgPixel));

  assert_collision_cause_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusCollision) |-> $past(pixValid));

endmodule

bind sprite_evaluator sprite_eval_checker #(.NUM_SLOTS(NUM_SLOTS), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .spriteCount(spriteCount), .statusOverflow(statusOverflow),
  .evalDone(evalDone), .pixSprite(pixSprite), .pixOut(pixOut), .bgPixel(bgPixel),
  .bgPriority(bgPriority), .statusCollision(statusCollision), .pixValid(pixValid)
);

// File: tb/sprite_evaluator_tb.sv
module sprite_evaluator_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lineStart = 1'b0, tallMode = 1'b0, earlyClock = 1'b0;
  logic [7:0] lineNum = '0;
  logic [7:0] tblAddr, tblData;
  logic evalDone, statusOverflow, statusAck = 1'b0, pixValid = 1'b0;
  logic [3:0] spriteCount;
  logic [71:0] slotX;
  logic [103:0] slotRowAddr;
  logic [47:0] slotIndex;
  logic [31:0] slotColor = '0;
  logic [4:0] bgPixel = '0, pixOut;
  logic bgPriority = 1'b0, pixSprite, statusCollision;

  logic [7:0] mem [256];
  int checks = 0, fails = 0, cycles = 0;
  int expCount;
  bit expOvf;
  logic [8:0] expX [8];
  logic [12:0] expRow [8];
  logic [5:0] expIdx [8];

  always #5 clk = ~clk;
  always @(posedge clk) tblData <= mem[tblAddr];

  sprite_evaluator u_dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  // Model of R1-R7
  task automatic model(input logic [7:0] line, input bit tall, input bit early);
    expCount = 0; expOvf = 0;
    for (int i = 0; i < 64; i++) begin
      logic [7:0] y, d, x, p, pe;
      y = mem[i];
      if (y == 8'hD0) break;
      d = line - y - 8'd1;
      if (d < (tall ? 8'd16 : 8'd8)) begin
        if (expCount == 8) begin expOvf = 1; break; end
        x = mem[128 + 2*i]; p = mem[129 + 2*i];
        expX[expCount] = early ? ({1'b0, x} - 9'd8) : {1'b0, x};
        pe = tall ? {p[7:1], d[3]} : p;
        expRow[expCount] = {pe, d[2:0], 2'b00};
        expIdx[expCount] = 6'(i);
        expCount++;
      end
    end
  endtask

  task automatic ack();
    @(negedge clk); statusAck = 1'b1;
    @(negedge clk); statusAck = 1'b0;
  endtask

  task automatic runLine(input logic [7:0] line, input bit tall, input bit early,
                         input bit poke, input string req);
    int w;
    ack();
    model(line, tall, early);
    lineNum = line; tallMode = tall; earlyClock = early; lineStart = 1'b1;
    @(negedge clk); lineStart = 1'b0;
    if (poke) begin
      // R8: a second start mid-walk with other settings must be ignored
      @(negedge clk); @(negedge clk);
      lineNum = line + 8'd40; tallMode = !tall; lineStart = 1'b1;
      @(negedge clk); lineStart = 1'b0;
    end
    w = 0;
    while (!evalDone && w < 2000) begin @(negedge clk); w++; end
    chk(evalDone, "R8 done pulse", evalDone, 1);
    chk(spriteCount == expCount, {req, " R5 count"}, spriteCount, expCount);
    chk(statusOverflow == expOvf, {req, " R6 overflow"}, statusOverflow, expOvf);
    for (int s = 0; s < 8; s++) begin
      if (s < expCount) begin
        chk(slotX[s*9 +: 9] == expX[s], {req, " R7 slotX"}, slotX[s*9 +: 9], expX[s]);
        chk(slotRowAddr[s*13 +: 13] == expRow[s], {req, " R4 rowAddr"},
            slotRowAddr[s*13 +: 13], expRow[s]);
        chk(slotIndex[s*6 +: 6] == expIdx[s], {req, " R1 index"}, slotIndex[s*6 +: 6], expIdx[s]);
      end
    end
    @(negedge clk);
    chk(!evalDone, "R8 done one cycle", evalDone, 0);
  endtask

  task automatic mixTest(input logic [31:0] cols, input logic [4:0] bg, input bit pri);
    logic [3:0] win; int nOp; bit hid, spr; logic [4:0] ePix;
    ack();
    win = 0; nOp = 0;
    for (int s = 7; s >= 0; s--)
      if (s < expCount && cols[s*4 +: 4] != 0) begin win = cols[s*4 +: 4]; nOp++; end
    hid = pri && bg[3:0] != 0;
    spr = nOp > 0 && !hid;
    ePix = spr ? {1'b1, win} : bg;
    slotColor = cols; bgPixel = bg; bgPriority = pri; pixValid = 1'b1;
    #1;
    chk(pixSprite == spr, spr ? "R9 sprite shown" : "R10 sprite hidden", pixSprite, spr);
    chk(pixOut == ePix, hid ? "R10 priority pixel" : "R9 mixed pixel", pixOut, ePix);
    @(negedge clk); pixValid = 1'b0;
    chk(statusCollision == (nOp >= 2), "R11 collision", statusCollision, nOp >= 2);
  endtask

  task automatic clearTable();
    for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
    for (int i = 0; i < 64; i++) mem[i] = 8'hC0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    clearTable();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(spriteCount == 0, "R12 count", spriteCount, 0);
    chk(!statusOverflow && !statusCollision, "R12 flags", {statusOverflow, statusCollision}, 0);
    chk(!evalDone, "R12 done", evalDone, 0);

    // R2: Y=0xFF is row 0 of line 0
    mem[5] = 8'hFF; mem[128+10] = 8'h40; mem[129+10] = 8'h21;
    runLine(8'd0, 0, 0, 0, "R2 yff");
    chk(spriteCount == 1 && slotRowAddr[12:0] == 13'h0420, "R2 row0", slotRowAddr[12:0], 13'h0420);

    // R4: wrap Y=0xF5 on line 3 in tall mode gives row 13, odd pattern half
    clearTable();
    mem[2] = 8'hF5; mem[129+4] = 8'h37;
    runLine(8'd3, 1, 0, 0, "R4 tall wrap");
    chk(slotRowAddr[12:0] == {8'h37, 3'd5, 2'b00}, "R4 lower half", slotRowAddr[12:0],
        {8'h37, 3'd5, 2'b00});
    runLine(8'd3, 0, 0, 0, "R2 short miss");

    // R3: terminator before an in-range sprite
    clearTable();
    mem[0] = 8'd49; mem[3] = 8'hD0; mem[4] = 8'd49;
    for (int i = 5; i < 20; i++) mem[i] = 8'd49;
    runLine(8'd52, 0, 0, 0, "R3 term");
    chk(spriteCount == 1, "R3 stop", spriteCount, 1);

    // R5/R6: ten stacked sprites
    clearTable();
    for (int i = 10; i < 20; i++) mem[i] = 8'd99;
    runLine(8'd100, 0, 0, 0, "R6 stack");
    chk(statusOverflow == 1, "R6 ninth", statusOverflow, 1);

    // R7: early clock on X=3
    clearTable();
    mem[0] = 8'd9; mem[128] = 8'd3;
    runLine(8'd12, 0, 1, 0, "R7 early");
    chk(slotX[8:0] == 9'h1FB, "R7 negative", slotX[8:0], 9'h1FB);

    // R8: ignored restart
    clearTable();
    for (int i = 0; i < 64; i += 7) mem[i] = 8'd60;
    runLine(8'd63, 0, 0, 1, "R8 busy");

    // random tables
    for (int n = 0; n < 30; n++) begin
      logic [7:0] ln;
      ln = 8'($urandom_range(0, 223));
      for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
      for (int i = 0; i < 64; i++) begin
        int r = $urandom_range(0, 99);
        if (r < 3) mem[i] = 8'hD0;
        else if (r < 40) mem[i] = ln - 8'($urandom_range(1, 16));
        else if (mem[i] == 8'hD0) mem[i] = 8'hD1;
      end
      runLine(ln, 1'($urandom), 1'($urandom), 0, "R1 random");
    end

    // mixer with five slots filled
    clearTable();
    for (int i = 0; i < 5; i++) mem[i * 3] = 8'd20;
    runLine(8'd22, 0, 0, 0, "R9 setup");
    mixTest(32'h9000_0000, 5'h03, 0);        // slot 7 beyond count: masked
    mixTest(32'h0000_5060, 5'h03, 0);        // slot1 wins over slot3
    mixTest(32'h0000_0070, 5'h02, 1);        // priority over opaque bg
    mixTest(32'h0000_0070, 5'h10, 1);        // priority over transparent bg
    mixTest(32'h0000_0000, 5'h0A, 0);        // no sprite
    for (int n = 0; n < 40; n++)
      mixTest($urandom & $urandom, 5'($urandom), 1'($urandom));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule